// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block sits between a requester issuing single-byte reads and writes and a byte-addressable backing RAM with a 16-bit address space. It holds 512 bytes as 64 direct-mapped lines of 8 bytes. Every read returns the whole 8-byte line that contains the address, a hit flag, and the dirty status the line had before the access. Writes go only to the cache: a write miss first pulls the line in from RAM and then merges the byte. A modified line goes back to RAM only when another tag displaces it.

The RAM port moves whole aligned lines. A request is held steady until the RAM answers with a ready pulse, and read data is taken in the cycle of that pulse. Only one request is in flight at a time. `ready_o` is high only while the block is idle, and it stays low through any RAM traffic caused by a miss.

Top module: `dm_wb_cache`

## Requirements
- R1: An address splits into offset = addr[2:0], index = addr[8:3] and tag = addr[15:9]. Two addresses conflict only when their indexes match and their tags differ. Every RAM address has bits [2:0] equal to 0.
- R2: A read hit raises `rsp_valid_o` in the cycle after the request is accepted, with `rsp_hit_o`=1, `rsp_addr_o` equal to the request address, and the byte at offset k in bits [8k+7:8k] of `rsp_line_o`. A read hit makes no RAM request.
- R3: A write hit updates only the addressed byte and marks the line dirty. It makes no RAM request, and `ready_o` stays high.
- R4: A write miss reads the line from RAM, merges the byte into it, and leaves the line dirty. A write produces no read response.
- R5: `rsp_dirty_o` carries the line's dirty bit as it was before the access. A read miss that replaces a dirty line reports 1, and a later read hit on the refilled line reports 0.
- R6: On a miss to a valid dirty line, the victim line is written to RAM at {victim tag, index, 000} before the refill read is issued.
- R7: A line that was evicted and fetched again returns the bytes written before the eviction.
- R8: After reset every line is invalid and all data reads as zero. A miss on an invalid or clean line writes nothing back, and a cold read miss reports hit 0, dirty 0 and an all-zero line.
- R9: `ready_o` is low from the acceptance of a miss until it completes, and a read-miss response arrives in the cycle `ready_o` returns high. `mem_req_o`, `mem_we_o` and `mem_addr_o` hold steady until `mem_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; taken when ready_o is high |
| req_write_i | input | 1 | 1 = byte write, 0 = read |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Idle and able to accept a request |
| rsp_valid_o | output | 1 | One-cycle pulse carrying a read response |
| rsp_addr_o | output | 16 | Address of the answered read |
| rsp_line_o | output | 64 | Line contents, lowest byte in bits [7:0] |
| rsp_hit_o | output | 1 | 1 = read hit |
| rsp_dirty_o | output | 1 | Dirty bit before the access |
| mem_req_o | output | 1 | RAM line transfer requested |
| mem_we_o | output | 1 | 1 = writeback, 0 = refill read |
| mem_addr_o | output | 16 | Line-aligned RAM address |
| mem_wdata_o | output | 64 | Writeback line |
| mem_ready_i | input | 1 | RAM completes the transfer this cycle |
| mem_rdata_i | input | 64 | Refill line, valid with mem_ready_i |

## Verification
The hardest case to reach is a read miss that displaces a dirty line. It needs a write to one tag, then an access to a second tag with the same index, and only then does the pre-access dirty flag, the writeback ordering and the later refetch all show up together. Directed tasks build exactly this chain using addresses 0x3F68.. and 0x8568.., which share index 0x2D. A reference-model sweep then crosses four tags with four indexes under changing RAM latencies, so that clean, dirty and invalid victims occur many times.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
  parameter int unsigned LINES = 64,
  parameter int unsigned TAG_W = 7,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_dirty_i
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= wr_dirty_i;
        tag_q[g]   <= wr_tag_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirty_q & ~valid_q) == '0); // R8
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
  parameter int unsigned LINES      = 64,
  parameter int unsigned LINE_BYTES = 8,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_base_i,
  input  logic              merge_en_i,
  input  logic [OFF_W-1:0]  merge_off_i,
  input  logic [7:0]        merge_byte_i
);
  logic [LINE_W-1:0] line_q [LINES];
  logic [LINE_W-1:0] merged;

  // byte lane replace
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = (merge_en_i && merge_off_i == OFF_W'(b)) ?
                              merge_byte_i : wr_base_i[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(LINES); i++) line_q[i] <= '0;
    end else if (wr_en_i) begin
      line_q[wr_idx_i] <= merged;
    end
  end

  assign rd_line_o = line_q[rd_idx_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINES      = 64,
  parameter int unsigned LINE_BYTES = 8,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned LINE_W = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [LINE_W-1:0] rsp_line_o,
  output logic              rsp_hit_o,
  output logic              rsp_dirty_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [LINE_W-1:0] mem_rdata_i,
  // array lookup
  output logic [IDX_W-1:0]  lk_idx_o,
  input  logic              lk_valid_i,
  input  logic              lk_dirty_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [LINE_W-1:0] lk_line_i,
  // array update
  output logic              upd_en_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic [TAG_W-1:0]  upd_tag_o,
  output logic              upd_dirty_o,
  output logic [LINE_W-1:0] upd_base_o,
  output logic              upd_merge_o,
  output logic [OFF_W-1:0]  upd_off_o,
  output logic [7:0]        upd_byte_o
);
  dmc_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, dirty_q;
  logic [7:0]        wdata_q;
  logic [TAG_W-1:0]  vtag_q;

  logic              rsp_valid_q, rsp_hit_q, rsp_dirty_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [LINE_W-1:0] rsp_line_q;

  logic [IDX_W-1:0] in_idx, q_idx;
  logic [TAG_W-1:0] in_tag, q_tag;
  logic idle, accept, in_hit, fill_done, victim_dirty;

  assign in_idx = req_addr_i[OFF_W +: IDX_W];
  assign in_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign q_idx  = addr_q[OFF_W +: IDX_W];
  assign q_tag  = addr_q[ADDR_W-1 -: TAG_W];

  assign idle         = (state_q == ST_IDLE);
  assign accept       = idle && req_valid_i;
  assign lk_idx_o     = idle ? in_idx : q_idx;
  assign in_hit       = lk_valid_i && (lk_tag_i == in_tag);
  assign victim_dirty = lk_valid_i && lk_dirty_i;
  assign fill_done    = (state_q == ST_FILL) && mem_ready_i;

  // array update: write hit in idle, refill completion otherwise
  assign upd_en_o    = (accept && in_hit && req_write_i) || fill_done;
  assign upd_idx_o   = idle ? in_idx : q_idx;
  assign upd_tag_o   = idle ? in_tag : q_tag;
  assign upd_dirty_o = idle ? 1'b1 : we_q;
  assign upd_base_o  = idle ? lk_line_i : mem_rdata_i;
  assign upd_merge_o = idle ? 1'b1 : we_q;
  assign upd_off_o   = idle ? req_addr_i[OFF_W-1:0] : addr_q[OFF_W-1:0];
  assign upd_byte_o  = idle ? req_wdata_i : wdata_q;

  assign mem_req_o   = !idle;
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = mem_we_o ? {vtag_q, q_idx, {OFF_W{1'b0}}}
                                : {q_tag,  q_idx, {OFF_W{1'b0}}};
  assign mem_wdata_o = lk_line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      dirty_q     <= 1'b0;
      vtag_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_dirty_q <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_line_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (in_hit) begin
            if (!req_write_i) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
              rsp_dirty_q <= lk_dirty_i;
              rsp_addr_q  <= req_addr_i;
              rsp_line_q  <= lk_line_i;
            end
          end else begin
            addr_q  <= req_addr_i;
            we_q    <= req_write_i;
            wdata_q <= req_wdata_i;
            dirty_q <= victim_dirty;
            vtag_q  <= lk_tag_i;
            state_q <= victim_dirty ? ST_WB : ST_FILL;
          end
        end
        ST_WB: if (mem_ready_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ready_i) begin
          state_q <= ST_IDLE;
          if (!we_q) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            rsp_dirty_q <= dirty_q;
            rsp_addr_q  <= addr_q;
            rsp_line_q  <= mem_rdata_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = idle;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign rsp_line_o  = rsp_line_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_dirty_o = rsp_dirty_q;

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
  AST_WB_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ready_i |=> mem_req_o && !mem_we_o); // R6
  AST_CLEAN_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !in_hit && !victim_dirty |=> !mem_we_o); // R8
  AST_HIT_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> $past(!mem_req_o)); // R2
  AST_MISS_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> $past(mem_req_o && !mem_we_o && mem_ready_i)); // R9
  AST_RSP_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ready_o); // R9
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LINES      = 64,
  parameter int unsigned LINE_BYTES = 8,
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int unsigned LINE_W = LINE_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [LINE_W-1:0] rsp_line_o,
  output logic              rsp_hit_o,
  output logic              rsp_dirty_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);
  logic [IDX_W-1:0]  lk_idx, upd_idx;
  logic              lk_valid, lk_dirty, upd_en, upd_dirty, upd_merge;
  logic [TAG_W-1:0]  lk_tag, upd_tag;
  logic [LINE_W-1:0] lk_line, upd_base;
  logic [OFF_W-1:0]  upd_off;
  logic [7:0]        upd_byte;

  dmc_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .ready_o, .rsp_valid_o, .rsp_addr_o, .rsp_line_o, .rsp_hit_o, .rsp_dirty_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .lk_idx_o(lk_idx), .lk_valid_i(lk_valid), .lk_dirty_i(lk_dirty),
    .lk_tag_i(lk_tag), .lk_line_i(lk_line),
    .upd_en_o(upd_en), .upd_idx_o(upd_idx), .upd_tag_o(upd_tag),
    .upd_dirty_o(upd_dirty), .upd_base_o(upd_base), .upd_merge_o(upd_merge),
    .upd_off_o(upd_off), .upd_byte_o(upd_byte)
  );

  dmc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_valid_o(lk_valid), .rd_dirty_o(lk_dirty), .rd_tag_o(lk_tag),
    .wr_en_i(upd_en), .wr_idx_i(upd_idx), .wr_tag_i(upd_tag), .wr_dirty_i(upd_dirty)
  );

  dmc_data_array #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) i_data (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_line_o(lk_line),
    .wr_en_i(upd_en), .wr_idx_i(upd_idx), .wr_base_i(upd_base),
    .merge_en_i(upd_merge), .merge_off_i(upd_off), .merge_byte_i(upd_byte)
  );

  AST_RAM_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFF_W-1:0] == '0); // R1
endmodule

// File: tb/test_dm_wb_cache.sv
`timescale 1ns/1ps
module test_dm_wb_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rsp_valid, rsp_hit, rsp_dirty;
  logic [15:0] rsp_addr, mem_addr;
  logic [63:0] rsp_line, mem_wdata;
  logic        mem_req, mem_we;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata = '0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dm_wb_cache i_dm_wb_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .ready_o(ready), .rsp_valid_o(rsp_valid),
    .rsp_addr_o(rsp_addr), .rsp_line_o(rsp_line), .rsp_hit_o(rsp_hit),
    .rsp_dirty_o(rsp_dirty), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata)
  );

  // backing RAM, zero initialised, line keyed
  logic [63:0] ram [int];
  int ram_lat = 1, ram_cnt = 0;
  int txn_cnt = 0, wb_cnt = 0, misalign = 0;
  logic [15:0] last_wb_addr = '0;
  logic [63:0] last_wb_data = '0;

  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      ram_cnt   <= 0;
      txn_cnt   <= txn_cnt + 1;
      if (mem_we) begin
        ram[int'(mem_addr >> 3)] = mem_wdata;
        wb_cnt       <= wb_cnt + 1;
        last_wb_addr <= mem_addr;
        last_wb_data <= mem_wdata;
      end
    end else if (mem_req && rst_n) begin
      if (mem_addr[2:0] != 3'b0) misalign <= misalign + 1;
      if (ram_cnt >= ram_lat) begin
        mem_ready <= 1'b1;
        mem_rdata <= ram.exists(int'(mem_addr >> 3)) ? ram[int'(mem_addr >> 3)] : 64'h0;
      end else ram_cnt <= ram_cnt + 1;
    end
  end

  // reference model
  logic [7:0] exp_mem [int];
  bit         m_valid [64];
  bit         m_dirty [64];
  logic [6:0] m_tag   [64];
  int exp_txn = 0, exp_wb = 0;

  function automatic logic [63:0] exp_line(input logic [15:0] a);
    logic [63:0] l;
    for (int b = 0; b < 8; b++) begin
      int k = int'({a[15:3], 3'b000}) + b;
      l[b*8 +: 8] = exp_mem.exists(k) ? exp_mem[k] : 8'h00;
    end
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request through the port, checked against the model
  task automatic op(input bit wr, input logic [15:0] a, input logic [7:0] d);
    logic [5:0]  idx = a[8:3];
    logic [6:0]  tg  = a[15:9];
    bit          hit, pdirty, wb;
    logic [15:0] vaddr;
    logic [63:0] vline;
    int          n;
    while (!ready) @(negedge clk);
    hit    = m_valid[idx] && m_tag[idx] == tg;
    pdirty = m_valid[idx] && m_dirty[idx];
    wb     = !hit && pdirty;
    vaddr  = {m_tag[idx], idx, 3'b000};
    vline  = exp_line(vaddr);
    if (!hit) begin
      exp_txn += wb ? 2 : 1;
      if (wb) exp_wb++;
      m_valid[idx] = 1'b1; m_tag[idx] = tg; m_dirty[idx] = 1'b0;
    end
    if (wr) begin exp_mem[int'(a)] = d; m_dirty[idx] = 1'b1; end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) chk(!ready, "R9", "ready low after miss", 64'(ready), 64'h0);
    n = 0;
    if (wr) begin
      while (!ready && n < 100) begin
        if (rsp_valid) chk(1'b0, "R4", "write response", 64'h1, 64'h0);
        @(negedge clk); n++;
      end
      chk(!rsp_valid, "R4", "no write response", 64'(rsp_valid), 64'h0);
    end else begin
      while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
      if (hit) chk(n == 0, "R2", "hit latency", 64'(n), 64'h0);
      chk(rsp_valid && ready, "R9", "rsp with ready", 64'({rsp_valid, ready}), 64'h3);
      chk(rsp_hit == hit, "R2", "hit flag", 64'(rsp_hit), 64'(hit));
      chk(rsp_dirty == pdirty, "R5", "dirty before access", 64'(rsp_dirty), 64'(pdirty));
      chk(rsp_addr == a, "R2", "rsp addr", 64'(rsp_addr), 64'(a));
      chk(rsp_line == exp_line(a), "R7", "line data", rsp_line, exp_line(a));
    end
    @(negedge clk);
    chk(txn_cnt == exp_txn, hit ? "R3" : "R8", "ram transfers", 64'(txn_cnt), 64'(exp_txn));
    chk(wb_cnt == exp_wb, "R6", "writeback count", 64'(wb_cnt), 64'(exp_wb));
    if (wb) begin
      chk(last_wb_addr == vaddr, "R6", "writeback addr", 64'(last_wb_addr), 64'(vaddr));
      chk(last_wb_data == vline, "R6", "writeback data", last_wb_data, vline);
    end
  endtask

  task automatic t_reset;
    chk(ready && !rsp_valid && !mem_req, "R8", "idle after reset",
        64'({ready, rsp_valid, mem_req}), 64'h4);
  endtask

  task automatic t_cold_read;  // R8 then R2
    op(0, 16'h3F6F, 8'h00);
    op(0, 16'h3F68, 8'h00);
  endtask

  task automatic t_write_hit;  // R3
    int t0;
    op(0, 16'h3F6A, 8'h00);
    t0 = txn_cnt;
    op(1, 16'h3F6A, 8'h4C);
    chk(txn_cnt == t0, "R3", "write hit no ram", 64'(txn_cnt), 64'(t0));
    op(0, 16'h3F6E, 8'h00);
  endtask

  task automatic t_write_miss_evict;  // R4, R6: 0x856C shares index 0x2D
    ram_lat = 3;
    op(1, 16'h856C, 8'h2E);
    op(0, 16'h8568, 8'h00);
    ram_lat = 1;
  endtask

  task automatic t_dirty_read_miss;  // R5, R7
    op(0, 16'h3F69, 8'h00);
    op(0, 16'h3F69, 8'h00);
    op(0, 16'h856C, 8'h00);
  endtask

  task automatic t_index_map;  // R1
    ram_lat = 0;
    op(1, 16'h0000, 8'h11);
    op(1, 16'h0008, 8'h22);
    op(1, 16'h0205, 8'h33);
    op(0, 16'h0008, 8'h00);
    op(0, 16'h0203, 8'h00);
    op(0, 16'h0001, 8'h00);
    ram_lat = 1;
  endtask

  task automatic t_sweep;  // all requirements under mixed traffic
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {lfsr[1:0], 5'h05, 4'h0, lfsr[3:2], lfsr[6:4]};
      if (i % 50 == 0) ram_lat = (i / 50) % 4;
      op(lfsr[7], a, lfsr[15:8]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_read();
    t_write_hit();
    t_write_miss_evict();
    t_dirty_read_miss();
    t_index_map();
    t_sweep();
    chk(misalign == 0, "R1", "aligned ram addresses", 64'(misalign), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule